// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the byte a host reads back while a NOR-style flash model is busy with an internal program or erase job. It counts write pulses from the start of each command sequence. Once the final pulse of a program sequence (4 pulses) or an erase sequence (6 pulses) has landed, the read path stops returning array contents and returns a status byte instead. The host polls that byte until the job finishes.

The status byte carries three flags. The top bit is a polling bit that reveals whether the job has finished. Bit 6 inverts on every read strobe while the job runs. Bit 5 is a sticky flag that reports an overrun of the time limit. The block also tracks erase suspend and resume, and it allows a program job to run while an erase is suspended. A reset command drops every kind of status and returns the read path to array data in a single cycle. Command decoding, array storage and the operation timer live outside this block. It receives their results as single-cycle strobes.

Top module: `flash_op_status`

## Requirements
- R1: After reset, and whenever no status is being reported, `dout` equals `array_data` and `status_on` is 0.
- R2: A program sequence starts with a `we_rise` that carries `seq_start` and kind 1. Status appears only after the 4th write pulse of that sequence. After pulses 1 to 3, `dout` still equals `array_data`.
- R3: A chip erase (kind 2) or a sector erase (kind 3) shows status only after its 6th write pulse. After pulse 5 there is no status.
- R4: While a program or erase job runs, bit 6 inverts once in each cycle that has `ce_rd` or `oe_rd` high. When both strobes are high in the same cycle, bit 6 still inverts only once. In cycles without a read strobe, bit 6 holds.
- R5: While a job runs, bit 7 is the complement of `prog_msb` as latched on the final program pulse, or 0 for an erase. Bits 4..0 read 0 whenever status is shown, and bit 5 reads 0 unless the block has failed.
- R6: An `op_done` strobe during a running job ends the status. The next read returns `array_data`, and later reads no longer toggle.
- R7: An erase-suspend command (kind 4, a single pulse) during an erase inverts bit 6 once and enters the suspended state. In that state bit 7 reads 1, bit 6 holds across reads, and `op_done` and `op_timeout` have no effect. A resume command (kind 5) inverts bit 6 once and returns to the running erase, where bit 7 reads 0.
- R8: A program sequence issued while suspended runs with the status of R5. When it completes, the block returns to the suspended status and does not return to array data.
- R9: An `op_timeout` strobe during a running job sets bit 5 to 1. That state is sticky: bit 6 stops toggling, bit 7 keeps its polling value, and `op_done` is ignored.
- R10: A reset command (kind 6, a single pulse) clears every status, including the failed state, so that `dout` equals `array_data` on the next cycle.
- R11: A `we_rise` without `seq_start` outside an open sequence is ignored. A `seq_start` in the middle of a sequence restarts the count under the new kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we_rise | input | 1 | One-cycle event for the rising edge of a write pulse |
| seq_start | input | 1 | Marks the write pulse that opens a command sequence |
| cmd_kind | input | 3 | Command kind carried with `seq_start`: 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume, 6 reset |
| prog_msb | input | 1 | Bit 7 of the byte being programmed, taken on the final program pulse |
| ce_rd | input | 1 | Read strobe from the chip-enable toggling |
| oe_rd | input | 1 | Read strobe from the output-enable toggling |
| op_done | input | 1 | Completion strobe of the embedded job |
| op_timeout | input | 1 | Time-limit overrun strobe from the operation timer |
| array_data | input | 8 | Array contents at the read address |
| dout | output | 8 | Read value: status byte or array data |
| status_on | output | 1 | High while a status byte replaces array data |

## Verification
Program jobs are swept over all 256 data bytes. Each job is read with a different strobe style (chip-enable only, output-enable only, or both together), so the sweep separates a correct polling bit from an inverted one and a single inversion from a double one. Chip and sector erase sequences are each stopped one pulse short and then completed, which pins the pulse count for each kind. The suspend, resume, suspended-program, timeout and reset paths are each driven with read strobes and stray `op_done` or `op_timeout` strobes, so that ignored inputs show up at `dout`. A restarted sequence and a stray pulse with no sequence open check that the counter rejects inputs that must not start a job.

// File: rtl/flash_op_status_pkg.sv
package flash_op_status_pkg;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_PROG = 3'd1,
    K_CHIP = 3'd2,
    K_SECT = 3'd3,
    K_SUSP = 3'd4,
    K_RES  = 3'd5,
    K_RST  = 3'd6
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_SUSP  = 3'd3,
    ST_SPROG = 3'd4,
    ST_FAIL  = 3'd5
  } op_state_e;

  // status byte layout: poll, toggle, overrun, five zero bits
  function automatic logic [7:0] status_byte(logic poll, logic tog, logic ovr);
    return {poll, tog, ovr, 5'b00000};
  endfunction

  function automatic logic is_multi(cmd_kind_e k);
    return (k == K_PROG) || (k == K_CHIP) || (k == K_SECT);
  endfunction

  function automatic logic is_running(op_state_e s);
    return (s == ST_PROG) || (s == ST_ERASE) || (s == ST_SPROG);
  endfunction

endpackage

// File: rtl/fos_seq_counter.sv
module fos_seq_counter
  import flash_op_status_pkg::*;
#(
  parameter int PROG_PULSES  = 4,
  parameter int ERASE_PULSES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_rise,
  input  logic       seq_start,
  input  logic [2:0] cmd_kind,
  output logic       arm_prog,
  output logic       arm_erase,
  output logic       cmd_susp,
  output logic       cmd_res,
  output logic       cmd_rst
);
  localparam int MAXP = (PROG_PULSES > ERASE_PULSES) ? PROG_PULSES : ERASE_PULSES;
  localparam int CW   = $clog2(MAXP + 1);

  function automatic logic [CW-1:0] need_of(cmd_kind_e k);
    case (k)
      K_PROG:         return CW'(PROG_PULSES);
      K_CHIP, K_SECT: return CW'(ERASE_PULSES);
      default:        return CW'(1);
    endcase
  endfunction

  logic            open_q;
  logic [CW-1:0]   cnt_q;
  cmd_kind_e       kind_q;

  logic            first, step, seq_end;
  cmd_kind_e       cur_kind, in_kind;
  logic [CW-1:0]   cur_cnt;

  always_comb begin
    in_kind  = cmd_kind_e'(cmd_kind);
    first    = we_rise && seq_start;
    step     = we_rise && (first || open_q);
    cur_kind = first ? in_kind : kind_q;
    cur_cnt  = first ? CW'(1) : cnt_q + CW'(1);
    seq_end  = step && is_multi(cur_kind) && (cur_cnt == need_of(cur_kind));
  end

  assign arm_prog  = seq_end && (cur_kind == K_PROG);
  assign arm_erase = seq_end && ((cur_kind == K_CHIP) || (cur_kind == K_SECT));
  assign cmd_susp  = first && (in_kind == K_SUSP);
  assign cmd_res   = first && (in_kind == K_RES);
  assign cmd_rst   = first && (in_kind == K_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= K_NONE;
    end else if (step) begin
      open_q <= is_multi(cur_kind) && !seq_end;
      cnt_q  <= cur_cnt;
      kind_q <= cur_kind;
    end
  end

endmodule

// File: rtl/fos_toggle.sv
module fos_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ce_rd,
  input  logic oe_rd,
  input  logic kick,
  output logic tog,
  output logic flip
);
  assign flip = (active && (ce_rd || oe_rd)) || kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tog <= 1'b0;
    else if (flip) tog <= ~tog;
  end
endmodule

// File: rtl/fos_ctrl.sv
module fos_ctrl
  import flash_op_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      arm_prog,
  input  logic      arm_erase,
  input  logic      cmd_susp,
  input  logic      cmd_res,
  input  logic      cmd_rst,
  input  logic      prog_msb,
  input  logic      op_done,
  input  logic      op_timeout,
  output op_state_e state,
  output logic      poll,
  output logic      susp_take,
  output logic      res_take
);
  op_state_e st_n;
  logic      poll_n;

  always_comb begin
    st_n      = state;
    poll_n    = poll;
    susp_take = 1'b0;
    res_take  = 1'b0;
    if (cmd_rst) begin
      st_n   = ST_IDLE;
      poll_n = 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (arm_prog) begin
            st_n = ST_PROG; poll_n = ~prog_msb;
          end else if (arm_erase) begin
            st_n = ST_ERASE; poll_n = 1'b0;
          end
        end
        ST_PROG: begin
          if (op_timeout)   st_n = ST_FAIL;
          else if (op_done) begin st_n = ST_IDLE; poll_n = 1'b0; end
        end
        ST_ERASE: begin
          if (op_timeout)   st_n = ST_FAIL;
          else if (op_done) begin st_n = ST_IDLE; poll_n = 1'b0; end
          else if (cmd_susp) begin
            st_n = ST_SUSP; poll_n = 1'b1; susp_take = 1'b1;
          end
        end
        ST_SUSP: begin
          if (cmd_res) begin
            st_n = ST_ERASE; poll_n = 1'b0; res_take = 1'b1;
          end else if (arm_prog) begin
            st_n = ST_SPROG; poll_n = ~prog_msb;
          end
        end
        ST_SPROG: begin
          if (op_timeout)   st_n = ST_FAIL;
          else if (op_done) begin st_n = ST_SUSP; poll_n = 1'b1; end
        end
        ST_FAIL: ;
        default: begin st_n = ST_IDLE; poll_n = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      poll  <= 1'b0;
    end else begin
      state <= st_n;
      poll  <= poll_n;
    end
  end
endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
  import flash_op_status_pkg::*;
#(
  parameter int PROG_PULSES  = 4,
  parameter int ERASE_PULSES = 6,
  parameter int DW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_rise,
  input  logic          seq_start,
  input  logic [2:0]    cmd_kind,
  input  logic          prog_msb,
  input  logic          ce_rd,
  input  logic          oe_rd,
  input  logic          op_done,
  input  logic          op_timeout,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] dout,
  output logic          status_on
);
  // named internal events, visible to the bound checker
  logic      arm_prog_w, arm_erase_w, susp_w, res_w, rst_cmd_w;
  logic      susp_take_w, res_take_w, kick_w, run_w, fail_w, arm_any_w;
  logic      poll_w, tog_w, flip_w;
  op_state_e state_w;

  fos_seq_counter #(.PROG_PULSES(PROG_PULSES), .ERASE_PULSES(ERASE_PULSES)) u_seq (
    .clk(clk), .rst_n(rst_n), .we_rise(we_rise), .seq_start(seq_start),
    .cmd_kind(cmd_kind), .arm_prog(arm_prog_w), .arm_erase(arm_erase_w),
    .cmd_susp(susp_w), .cmd_res(res_w), .cmd_rst(rst_cmd_w)
  );

  fos_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_prog(arm_prog_w), .arm_erase(arm_erase_w),
    .cmd_susp(susp_w), .cmd_res(res_w), .cmd_rst(rst_cmd_w), .prog_msb(prog_msb),
    .op_done(op_done), .op_timeout(op_timeout), .state(state_w), .poll(poll_w),
    .susp_take(susp_take_w), .res_take(res_take_w)
  );

  assign run_w     = is_running(state_w);
  assign fail_w    = (state_w == ST_FAIL);
  assign kick_w    = susp_take_w || res_take_w;
  assign arm_any_w = arm_prog_w || arm_erase_w;

  fos_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .active(run_w), .ce_rd(ce_rd), .oe_rd(oe_rd),
    .kick(kick_w), .tog(tog_w), .flip(flip_w)
  );

  assign status_on = (state_w != ST_IDLE);

  generate
    if (DW > 8) begin : g_wide
      assign dout = status_on ? {{(DW-8){1'b0}}, status_byte(poll_w, tog_w, fail_w)} : array_data;
    end else begin : g_byte
      logic [7:0] sb;
      assign sb   = status_byte(poll_w, tog_w, fail_w);
      assign dout = status_on ? sb[7 -: DW] : array_data;
    end
  endgenerate
endmodule

// File: rtl/flash_op_status_chk.sv
module flash_op_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_rd,
  input logic       oe_rd,
  input logic       op_done,
  input logic       op_timeout,
  input logic       rst_cmd,
  input logic       arm_any,
  input logic       run,
  input logic       fail,
  input logic       flip,
  input logic       status_on,
  input logic [7:0] array_data,
  input logic [7:0] dout
);
  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (ce_rd || oe_rd) && !op_done && !op_timeout && !rst_cmd) |=> (dout[6] != $past(dout[6])));

  // R4
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_on && !flip && !rst_cmd) |=> (!status_on || dout[6] == $past(dout[6])));

  // R5
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_on |-> (dout[4:0] == 5'd0));

  // R1
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_on |-> (dout == array_data));

  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !rst_cmd) |=> (fail && $stable(dout[7:5])));

  // R9
  fail_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_on |-> (dout[5] == fail));

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> !status_on);

  // R2
  start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_on) |-> $past(arm_any));
endmodule

bind flash_op_status flash_op_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_rd(ce_rd), .oe_rd(oe_rd), .op_done(op_done),
  .op_timeout(op_timeout), .rst_cmd(rst_cmd_w), .arm_any(arm_any_w), .run(run_w),
  .fail(fail_w), .flip(flip_w), .status_on(status_on), .array_data(array_data),
  .dout(dout)
);

// File: tb/sim_flash_op_status.sv
module sim_flash_op_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we_rise = 0, seq_start = 0, prog_msb = 0;
  logic [2:0] cmd_kind = 0;
  logic       ce_rd = 0, oe_rd = 0, op_done = 0, op_timeout = 0;
  logic [7:0] array_data = 8'hC3;
  logic [7:0] dout;
  logic       status_on;
  int         errors = 0, checks = 0;
  bit         finished = 0;

  localparam logic [2:0] KP = 3'd1, KC = 3'd2, KS = 3'd3, KSU = 3'd4, KRE = 3'd5, KRS = 3'd6;

  always #2 clk = ~clk;

  flash_op_status u0 (
    .clk(clk), .rst_n(rst_n), .we_rise(we_rise), .seq_start(seq_start), .cmd_kind(cmd_kind),
    .prog_msb(prog_msb), .ce_rd(ce_rd), .oe_rd(oe_rd), .op_done(op_done),
    .op_timeout(op_timeout), .array_data(array_data), .dout(dout), .status_on(status_on)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // expected status byte with bit 6 taken as given
  function automatic logic [7:0] sbyte(logic p, logic t, logic f);
    return (8'(p) << 7) | (8'(t) << 6) | (8'(f) << 5);
  endfunction

  task automatic wp(input logic st, input logic [2:0] k, input logic m);
    we_rise = 1; seq_start = st; cmd_kind = k; prog_msb = m;
    @(negedge clk);
    we_rise = 0; seq_start = 0; cmd_kind = 0;
  endtask

  task automatic seq(input logic [2:0] k, input int n, input logic m);
    wp(1, k, m);
    for (int i = 1; i < n; i++) wp(0, k, m);
  endtask

  task automatic rd(input logic c, input logic o);
    ce_rd = c; oe_rd = o;
    @(negedge clk);
    ce_rd = 0; oe_rd = 0;
  endtask

  task automatic strobe_done();
    op_done = 1; @(negedge clk); op_done = 0;
  endtask

  task automatic strobe_to();
    op_timeout = 1; @(negedge clk); op_timeout = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset dout", dout, 8'hC3);
    chk("R1 reset status", {7'd0, status_on}, 8'd0);

    // R11 stray pulse without open sequence
    wp(0, KP, 1); wp(0, KP, 1); wp(0, KP, 1); wp(0, KP, 1);
    chk("R11 stray pulses", {7'd0, status_on}, 8'd0);

    // R2 pulse count for program
    wp(1, KP, 1);
    for (int i = 2; i <= 4; i++) begin
      if (i > 1) chk("R2 before last pulse", dout, array_data);
      wp(0, KP, 1);
    end
    chk("R2 status after 4th", {7'd0, status_on}, 8'd1);
    chk("R5 program poll msb1", dout & 8'hBF, sbyte(0, 0, 0));
    strobe_done();
    chk("R6 done", dout, array_data);

    // R2 R4 R5 R6 sweep of all program bytes
    for (int d = 0; d < 256; d++) begin
      logic [7:0] db = 8'(d);
      array_data = db ^ 8'h3C;
      seq(KP, 4, db[7]);
      chk("R5 poll bit sweep", dout & 8'hBF, sbyte(~db[7], 0, 0));
      t = dout[6];
      case (d % 3)
        0: rd(1, 0);
        1: rd(0, 1);
        default: rd(1, 1);
      endcase
      chk("R4 toggle on read", {7'd0, dout[6]}, {7'd0, ~t});
      @(negedge clk);
      chk("R4 hold without read", {7'd0, dout[6]}, {7'd0, ~t});
      array_data = db;
      strobe_done();
      chk("R6 data after done", dout, db);
      rd(1, 1);
      chk("R6 no toggle after done", dout, db);
    end

    // R3 chip and sector erase
    array_data = 8'h5A;
    seq(KC, 5, 0);
    chk("R3 chip 5 pulses", {7'd0, status_on}, 8'd0);
    wp(0, KC, 0);
    chk("R3 chip 6th", dout & 8'hBF, sbyte(0, 0, 0));
    chk("R3 chip on", {7'd0, status_on}, 8'd1);
    strobe_done();
    seq(KS, 5, 1);
    chk("R3 sector 5 pulses", dout, 8'h5A);
    wp(0, KS, 1);
    chk("R3 sector 6th", dout & 8'hBF, sbyte(0, 0, 0));
    t = dout[6];
    rd(0, 1);
    chk("R4 erase toggle", {7'd0, dout[6]}, {7'd0, ~t});

    // R7 suspend and resume
    t = dout[6];
    wp(1, KSU, 0);
    chk("R7 suspend", dout, sbyte(1, ~t, 0));
    rd(1, 0); rd(0, 1);
    chk("R7 frozen in suspend", dout, sbyte(1, ~t, 0));
    strobe_done(); strobe_to();
    chk("R7 done/timeout ignored", dout, sbyte(1, ~t, 0));

    // R8 program in suspend
    seq(KP, 4, 1);
    chk("R8 suspended program", dout & 8'hBF, sbyte(0, 0, 0));
    t = dout[6];
    rd(1, 0);
    chk("R8 toggles", {7'd0, dout[6]}, {7'd0, ~t});
    strobe_done();
    chk("R8 back to suspend", dout, sbyte(1, ~t, 0));
    wp(1, KRE, 0);
    chk("R7 resume", dout, sbyte(0, t, 0));

    // R9 timeout during erase
    strobe_to();
    chk("R9 overrun flag", dout, sbyte(0, t, 1));
    rd(1, 1); strobe_done();
    chk("R9 sticky frozen", dout, sbyte(0, t, 1));
    // R10 reset clears
    wp(1, KRS, 0);
    chk("R10 reset", dout, 8'h5A);

    // R9 timeout in program keeps poll
    seq(KP, 4, 1);
    t = dout[6];
    strobe_to();
    rd(0, 1);
    chk("R9 program overrun", dout, sbyte(0, t, 1));
    wp(1, KRS, 0);
    chk("R10 reset after program fail", {7'd0, status_on}, 8'd0);

    // R11 restart mid sequence
    wp(1, KP, 1); wp(0, KP, 1);
    wp(1, KC, 0); wp(0, KC, 0); wp(0, KC, 0);
    chk("R11 no status at old count", dout, 8'h5A);
    wp(0, KC, 0); wp(0, KC, 0);
    chk("R11 still counting", {7'd0, status_on}, 8'd0);
    wp(0, KC, 0);
    chk("R11 restarted erase", dout & 8'hBF, sbyte(0, 0, 0));
    wp(1, KRS, 0);
    chk("R10 final reset", dout, 8'h5A);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule